// File: doc/BRIEF.md
# Infrared Pulse-Distance Packet Transmitter

This block turns four active-high push-button inputs into infrared packets on a single output line that carries a square-wave carrier of about 38 kHz during each mark. All timing is counted from the 8 MHz system clock. The block picks the pressed button with the lowest index and maps it to a 3-bit code. It then sends a packet, keeps the line silent for a fixed gap, and sends the packet again for as long as that same button is held.

A packet has eight marks, and each mark is a burst of carrier lasting exactly six time-base ticks. The value of a symbol is given by the length of the silent space that follows its mark. The packet order is:

1. A header.
2. The three code bits, least significant first.
3. The complements of those three bits, in the same order.
4. A closing mark with no space of its own, after which the inter-packet gap begins.

The inputs are assumed to be synchronised and debounced already. The output drives an external LED driver.

Top module: `ir_pulse_tx`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `ir_o` is 0 and `busy_o` stays 0 until a button is sampled high.
- R2: Each mark starts with `ir_o` high in its first cycle. Within the mark, `ir_o` toggles every CARRIER_HALF clock cycles (default 105).
- R3: Each mark lasts MARK_TICKS ticks (default 6), and a tick is TICK_DIV clock cycles (default 800). The span from a mark's first high cycle to its last high cycle equals the part of that window that falls in high carrier phases.
- R4: The header mark is followed by a space of HDR_SPACE_TICKS ticks (default 30). The interval from header rise to the next mark's rise is therefore (6+30) ticks.
- R5: Data marks 1 to 6 are each followed by a space that encodes one bit: ONE_SPACE_TICKS (default 10) for a 1 and ZERO_SPACE_TICKS (default 20) for a 0. Marks 1 to 3 carry code bits 0, 1 and 2; marks 4 to 6 carry their complements in the same order.
- R6: The eighth mark is followed by GAP_TICKS ticks of silence (default 200) before the next packet's header mark.
- R7: The button with the lowest index among those pressed is chosen. Buttons 0, 1, 2 and 3 send codes 3'b001, 3'b100, 3'b101 and 3'b111.
- R8: Once a run has started, the chosen code does not change and other buttons are ignored. A new packet starts at the end of a gap only if the chosen button is still high; otherwise the run ends.
- R9: `busy_o` rises in the cycle after a button is first sampled in idle. It falls exactly (MARK_TICKS+GAP_TICKS) ticks after the last mark begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_i | input | 4 | Active-high buttons, index 0 has top priority |
| ir_o | output | 1 | Carrier-modulated infrared drive |
| busy_o | output | 1 | High while a run of packets is in progress |

## Verification
The hardest situation to reach from the ports is a second button appearing in the middle of a run. In that case the run must keep its original code, end once the first button is released, and then restart with the newly chosen code after only a single idle cycle. The stimulus reaches it in a directed case:

1. Hold button 2.
2. Add button 0 part-way through the run.
3. Release button 2 alone, leaving button 0 held.

The bench decodes every mark's spacing back into bits and compares the result with the priority code of each run. Random button subsets with random hold times place the release at arbitrary points within packets and gaps.

// File: rtl/irtx_pkg.sv
// Shared types and code table for the infrared packet transmitter.
package irtx_pkg;

    // Sequencer phases: idle, carrier mark, symbol space, inter-packet gap.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2,
        ST_GAP   = 2'd3
    } irtx_state_e;

    localparam int unsigned BTN_COUNT = 4;
    localparam int unsigned CODE_W    = 3;
    localparam int unsigned LAST_SYM  = 7;

    // Payload code assigned to each button index.
    function automatic logic [CODE_W-1:0] irtx_code(input logic [1:0] idx);
        case (idx)
            2'd0:    return 3'b001;
            2'd1:    return 3'b100;
            2'd2:    return 3'b101;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/irtx_scan.sv
// Button scan: reports whether any button is high and the index of the
// lowest-numbered one. Assumes inputs are already synchronous and clean.
module irtx_scan
    import irtx_pkg::*;
(
    input  logic [BTN_COUNT-1:0] btn_i,
    output logic                 any_o,
    output logic [1:0]           idx_o
);

    // Fixed-priority encode, lowest index wins.
    always_comb begin
        any_o = |btn_i;
        idx_o = 2'd0;
        for (int i = BTN_COUNT - 1; i >= 0; i--) begin
            if (btn_i[i]) idx_o = 2'(i);
        end
    end

endmodule

// File: rtl/irtx_tick.sv
// Time-base divider: pulses tick_o once every DIV clocks. While clr_i is
// high the count is held at zero, so the first tick after clr_i drops
// arrives exactly DIV cycles later.
module irtx_tick #(
    parameter int unsigned DIV = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    // Count clocks, wrapping at the tick boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  cnt_q <= '0;
        else if (tick_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/irtx_carrier.sv
// Carrier generator: a square wave that toggles every HALF clocks while
// en_i is high. The phase is rearmed high whenever en_i is low, so every
// mark starts with a full high half-period. The output is forced low
// outside marks.
module irtx_carrier #(
    parameter int unsigned HALF = 105
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic out_o
);

    localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt_q;
    logic         ph_q;

    assign out_o = en_i && ph_q;

    // Half-period counter and phase flop, rearmed outside marks.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
            ph_q  <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/irtx_seq.sv
// Symbol sequencer. It latches the chosen button and its code when idle,
// then walks eight marks (header, three bits, three complements, stop) with
// the spaces between them, followed by the inter-packet gap. At the end of
// the gap it repeats only if the latched button is still high.
// Assumes tick_i comes from a divider that is cleared while idle.
module irtx_seq
    import irtx_pkg::*;
#(
    parameter int unsigned MARK_TICKS       = 6,
    parameter int unsigned HDR_SPACE_TICKS  = 30,
    parameter int unsigned ZERO_SPACE_TICKS = 20,
    parameter int unsigned ONE_SPACE_TICKS  = 10,
    parameter int unsigned GAP_TICKS        = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 req_i,
    input  logic [1:0]           req_idx_i,
    input  logic [BTN_COUNT-1:0] btn_i,
    output logic                 mark_o,
    output logic                 busy_o,
    output logic                 tick_clr_o,
    output logic [CODE_W-1:0]    code_o
);

    localparam int unsigned MAX_A = (MARK_TICKS > HDR_SPACE_TICKS) ? MARK_TICKS : HDR_SPACE_TICKS;
    localparam int unsigned MAX_B = (ZERO_SPACE_TICKS > ONE_SPACE_TICKS) ? ZERO_SPACE_TICKS : ONE_SPACE_TICKS;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MAX_T = (MAX_C > GAP_TICKS) ? MAX_C : GAP_TICKS;
    localparam int unsigned SEG_W = $clog2(MAX_T + 1);

    irtx_state_e         state_q;
    logic [2:0]          sym_q;
    logic [SEG_W-1:0]    seg_q;
    logic [1:0]          sel_q;
    logic [CODE_W-1:0]   code_q;
    logic                bit_val;
    logic [SEG_W-1:0]    seg_len;
    logic                seg_done;

    // Bit carried by the current data symbol: true bits, then complements.
    always_comb begin
        case (sym_q)
            3'd1:    bit_val = code_q[0];
            3'd2:    bit_val = code_q[1];
            3'd3:    bit_val = code_q[2];
            3'd4:    bit_val = ~code_q[0];
            3'd5:    bit_val = ~code_q[1];
            3'd6:    bit_val = ~code_q[2];
            default: bit_val = 1'b0;
        endcase
    end

    // Length in ticks of the segment now in progress.
    always_comb begin
        case (state_q)
            ST_MARK:  seg_len = SEG_W'(MARK_TICKS);
            ST_SPACE: seg_len = (sym_q == 3'd0) ? SEG_W'(HDR_SPACE_TICKS)
                              : (bit_val ? SEG_W'(ONE_SPACE_TICKS) : SEG_W'(ZERO_SPACE_TICKS));
            ST_GAP:   seg_len = SEG_W'(GAP_TICKS);
            default:  seg_len = SEG_W'(1);
        endcase
    end

    assign seg_done = tick_i && (seg_q == seg_len - 1'b1);

    // Phase, symbol and tick-count progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sym_q   <= 3'd0;
            seg_q   <= '0;
            sel_q   <= 2'd0;
            code_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    seg_q <= '0;
                    if (req_i) begin
                        state_q <= ST_MARK;
                        sym_q   <= 3'd0;
                        sel_q   <= req_idx_i;
                        code_q  <= irtx_code(req_idx_i);
                    end
                end
                ST_MARK: begin
                    if (seg_done) begin
                        seg_q   <= '0;
                        state_q <= (sym_q == 3'(LAST_SYM)) ? ST_GAP : ST_SPACE;
                    end else if (tick_i) begin
                        seg_q <= seg_q + 1'b1;
                    end
                end
                ST_SPACE: begin
                    if (seg_done) begin
                        seg_q   <= '0;
                        sym_q   <= sym_q + 3'd1;
                        state_q <= ST_MARK;
                    end else if (tick_i) begin
                        seg_q <= seg_q + 1'b1;
                    end
                end
                default: begin
                    if (seg_done) begin
                        seg_q <= '0;
                        sym_q <= 3'd0;
                        state_q <= btn_i[sel_q] ? ST_MARK : ST_IDLE;
                    end else if (tick_i) begin
                        seg_q <= seg_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign mark_o     = (state_q == ST_MARK);
    assign busy_o     = (state_q != ST_IDLE);
    assign tick_clr_o = (state_q == ST_IDLE);
    assign code_o     = code_q;

endmodule

// File: rtl/ir_pulse_tx.sv
// Top level of the infrared pulse-distance packet transmitter. It ties
// together the button scan, the 100 us time base, the symbol sequencer and
// the carrier generator. Assumes clean, synchronous button inputs.
module ir_pulse_tx #(
    parameter int unsigned CARRIER_HALF     = 105,
    parameter int unsigned TICK_DIV         = 800,
    parameter int unsigned MARK_TICKS       = 6,
    parameter int unsigned HDR_SPACE_TICKS  = 30,
    parameter int unsigned ZERO_SPACE_TICKS = 20,
    parameter int unsigned ONE_SPACE_TICKS  = 10,
    parameter int unsigned GAP_TICKS        = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] btn_i,
    output logic       ir_o,
    output logic       busy_o
);

    logic       any_btn;
    logic [1:0] any_idx;
    logic       tick;
    logic       tick_clr;
    logic       mark;
    logic [2:0] code;

    irtx_scan u_scan (
        .btn_i (btn_i),
        .any_o (any_btn),
        .idx_o (any_idx)
    );

    irtx_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    irtx_seq #(
        .MARK_TICKS       (MARK_TICKS),
        .HDR_SPACE_TICKS  (HDR_SPACE_TICKS),
        .ZERO_SPACE_TICKS (ZERO_SPACE_TICKS),
        .ONE_SPACE_TICKS  (ONE_SPACE_TICKS),
        .GAP_TICKS        (GAP_TICKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .req_i      (any_btn),
        .req_idx_i  (any_idx),
        .btn_i      (btn_i),
        .mark_o     (mark),
        .busy_o     (busy_o),
        .tick_clr_o (tick_clr),
        .code_o     (code)
    );

    irtx_carrier #(.HALF(CARRIER_HALF)) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (mark),
        .out_o (ir_o)
    );

endmodule

// File: rtl/ir_pulse_tx_chk.sv
// Property checker for ir_pulse_tx, attached by bind. Observes the ports
// plus the internal mark enable and latched code.
module ir_pulse_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] btn_i,
    input logic       ir_o,
    input logic       busy_o,
    input logic       mark,
    input logic [2:0] code
);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ir_o);

    a_r2_mark_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mark) |-> ir_o);

    a_r9_busy_needs_button: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(|btn_i));

    a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(code));

    a_r6_gap_ends_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !$past(mark));

    a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (code == 3'b001 || code == 3'b100 || code == 3'b101 || code == 3'b111));

endmodule

bind ir_pulse_tx ir_pulse_tx_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .btn_i  (btn_i),
    .ir_o   (ir_o),
    .busy_o (busy_o),
    .mark   (mark),
    .code   (code)
);

// File: tb/ir_pulse_tx_tb_top.sv
module ir_pulse_tx_tb_top;

    localparam int H   = 3;
    localparam int TD  = 8;
    localparam int MK  = 6;
    localparam int HDR = 30;
    localparam int ZR  = 20;
    localparam int ON  = 10;
    localparam int GP  = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn = 4'd0;
    logic       ir_o;
    logic       busy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ir_pulse_tx #(
        .CARRIER_HALF(H), .TICK_DIV(TD), .MARK_TICKS(MK), .HDR_SPACE_TICKS(HDR),
        .ZERO_SPACE_TICKS(ZR), .ONE_SPACE_TICKS(ON), .GAP_TICKS(GP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .ir_o(ir_o), .busy_o(busy_o)
    );

    // Record one comparison.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] prio_code(input logic [3:0] v);
        if (v[0])      return 3'b001;
        else if (v[1]) return 3'b100;
        else if (v[2]) return 3'b101;
        else           return 3'b111;
    endfunction

    // Rise-to-rise interval after mark number pos.
    function automatic int exp_iv(input int pos, input logic [2:0] c);
        logic b;
        if (pos == 0) return (MK + HDR) * TD;
        if (pos == 7) return (MK + GP) * TD;
        b = (pos <= 3) ? c[pos-1] : ~c[pos-4];
        return (MK + (b ? ON : ZR)) * TD;
    endfunction

    // First-high to last-high span of one mark.
    function automatic int exp_span();
        int b = MK * TD;
        int s = ((b - 1) / (2 * H)) * 2 * H;
        return (s + H < b) ? s + H : b;
    endfunction

    logic [2:0] next_code = 3'd0;
    logic [2:0] cur_code;
    logic [2:0] rx_code;
    int  cyc = 0, start_c = 0, last_hi = 0, lo_run = 0, hi_run = 0, pos = 0;
    bit  have_b = 0, first_chk = 0, prev_out = 0, prev_busy = 0;

    // Output monitor: measure marks and spaces, decode bits.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!prev_busy && busy_o) begin
                cur_code = next_code;
                have_b = 0;
            end
            if (ir_o) begin
                if (!prev_out && (!have_b || lo_run > 2 * H)) begin
                    if (have_b) begin
                        chk(cyc - start_c == exp_iv(pos, cur_code),
                            (pos == 0) ? "R4 header" : (pos == 7) ? "R6 gap" : "R5 symbol",
                            cyc - start_c, exp_iv(pos, cur_code));
                        chk(last_hi - start_c + 1 == exp_span(), "R3 mark", last_hi - start_c + 1, exp_span());
                        if (pos >= 1 && pos <= 3)
                            rx_code[pos-1] = (cyc - start_c == (MK + ON) * TD);
                        if (pos == 3)
                            chk(rx_code == cur_code, "R7 code", int'(rx_code), int'(cur_code));
                        pos = (pos == 7) ? 0 : pos + 1;
                    end else begin
                        pos = 0;
                    end
                    have_b = 1; start_c = cyc; first_chk = 0; hi_run = 0;
                end
                hi_run++; last_hi = cyc; lo_run = 0;
            end else begin
                if (prev_out && !first_chk) begin
                    chk(hi_run == H, "R2 carrier", hi_run, H);
                    first_chk = 1;
                end
                lo_run++;
            end
            if (prev_busy && !busy_o) begin
                chk(have_b && pos == 7, "R9 end pos", pos, 7);
                chk(cyc - start_c == (MK + GP) * TD, "R9 busy fall", cyc - start_c, (MK + GP) * TD);
                chk(last_hi - start_c + 1 == exp_span(), "R3 stop mark", last_hi - start_c + 1, exp_span());
                have_b = 0;
            end
            if (!busy_o && ir_o) chk(0, "R1 idle output", 1, 0);
        end
        prev_out = ir_o;
        prev_busy = busy_o;
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // One press: start, hold, release, wait for the run to end.
    task automatic press(input logic [3:0] v, input int hold);
        @(negedge clk);
        next_code = prio_code(v);
        btn = v;
        @(negedge clk);
        chk(busy_o == 1'b1, "R9 busy rise", int'(busy_o), 1);
        chk(ir_o == 1'b1, "R2 first phase", int'(ir_o), 1);
        repeat (hold) @(negedge clk);
        btn = 4'd0;
        wait_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(ir_o == 1'b0 && busy_o == 1'b0, "R1 in reset", int'(ir_o), 0);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        chk(ir_o == 1'b0, "R1 idle ir", int'(ir_o), 0);
        chk(busy_o == 1'b0, "R1 idle busy", int'(busy_o), 0);

        // R7 each button alone, two packets each.
        for (int i = 0; i < 4; i++) press(4'(1 << i), 3500);
        // R8 one-cycle press still sends a whole packet.
        press(4'b1000, 1);

        // R8 a higher-priority button joining mid-run is ignored.
        @(negedge clk);
        next_code = prio_code(4'b0100);
        btn = 4'b0100;
        repeat (500) @(negedge clk);
        next_code = prio_code(4'b0001);
        btn = 4'b0101;
        repeat (3500) @(negedge clk);
        btn = 4'b0001;
        while (busy_o) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(busy_o == 1'b1, "R8 restart with new button", int'(busy_o), 1);
        repeat (1000) @(negedge clk);
        btn = 4'd0;
        wait_idle();

        // Random subsets and hold times.
        for (int k = 0; k < 8; k++) begin
            logic [3:0] v;
            int h;
            v = 4'(($urandom % 15) + 1);
            h = int'($urandom % 5000) + 1;
            press(v, h);
        end

        repeat (100) @(negedge clk);
        chk(ir_o == 1'b0 && busy_o == 1'b0, "R1 final idle", int'(busy_o), 0);
        summary();
    end

endmodule